// File: doc/BRIEF.md
# Dual-Clock Mailbox Pair

This block gives two independently clocked ports a side channel for single words that bypasses the bulk data queue. Port A sends to port B through one mailbox register, called mail1. Port B sends to port A through the other, called mail2. Each mailbox has a status flag that is high while the mailbox is free and low while a stored word waits to be taken. The port that writes a mailbox pulls its flag low at once. The port that reads the mailbox releases it, and that release event is carried back into the writer's clock domain before the flag rises again.

Each port presents a clock, a chip select, an enable, a direction bit and a mailbox select. Port B's read data output chooses between mail1 and the queue word supplied by the queue array that sits beside this block. Port A's read data output chooses between mail2 and zero, because the queue never flows towards port A. Each flag lives in the clock domain of the port that writes its mailbox. A toggle handshake with a two-stage synchronizer carries events in each direction.

Top module: `xmbox_pair`

## Requirements
- R1: An access takes place only on a rising edge of the port's own clock at which both its chip select and its enable are high. The direction bit picks the kind of access: 1 is a write and 0 is a read. Only an access with the mailbox select high acts on a mailbox. When either qualifier is low, the mailbox word and both flags stay as they are.
- R2: A port-A mailbox write made while `m1_free` is high stores `a_wdata` into mail1. `m1_free` goes low on that same clock-A edge.
- R3: A port-B mailbox write made while `m2_free` is high stores `b_wdata` into mail2. `m2_free` goes low on that same clock-B edge.
- R4: A port-B mailbox read of an unread mail1 word raises `m1_free` on the third rising clock-A edge after the read edge. The flag is still low after the second of those edges.
- R5: A port-A mailbox read of an unread mail2 word raises `m2_free` on the third rising clock-B edge after the read edge. The flag is still low after the second of those edges.
- R6: A mailbox write made while that mailbox's flag is low is ignored. The stored word and the flag keep their values for as long as the mail stays unread.
- R7: A mailbox read has no effect when no unread word has reached the reader's domain. After such a read, the next write still holds the flag low until a later real read.
- R8: `b_rdata` equals mail1 while `b_mb` is high and equals `b_fifo_data` while `b_mb` is low. `a_rdata` equals mail2 while `a_mb` is high and is zero while `a_mb` is low. A port can therefore read back only the mailbox that the opposite port writes.
- R9: Reset is synchronous and active high, and it must be held for at least four edges of each clock. It sets `m1_free` and `m2_free` high and clears both mailbox words to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, unrelated to clk_a |
| rst | input | 1 | Synchronous active-high reset, seen by both domains |
| a_cs | input | 1 | Port A chip select, active high |
| a_en | input | 1 | Port A enable, active high |
| a_wr | input | 1 | Port A direction, 1 write, 0 read |
| a_mb | input | 1 | Port A mailbox select |
| a_wdata | input | 36 | Port A write data |
| a_rdata | output | 36 | Port A read data: mail2 or zero |
| b_cs | input | 1 | Port B chip select, active high |
| b_en | input | 1 | Port B enable, active high |
| b_wr | input | 1 | Port B direction, 1 write, 0 read |
| b_mb | input | 1 | Port B mailbox select |
| b_wdata | input | 36 | Port B write data |
| b_fifo_data | input | 36 | Queue output word routed to port B when b_mb is low |
| b_rdata | output | 36 | Port B read data: mail1 or queue word |
| m1_free | output | 1 | Mail1 flag in the clock-A domain, low while mail waits |
| m2_free | output | 1 | Mail2 flag in the clock-B domain, low while mail waits |

## Verification
A toggle that goes out of step between the two domains shows up at once as a flag with the wrong level. It appears either at the writing edge, as a flag that will not drop, or three edges after a read, as a flag that rises without a real read or stays low after one. A mailbox word that is overwritten while unread appears on the reader's data output as soon as the opposite port raises its mailbox select. The flag latency is therefore checked exactly, at the second and third writer-clock edges after each read. Stale-read and blocked-write cases are held open for several extra cycles so that any late release gets a chance to surface.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned MBX_DATA_W      = 36;
    localparam int unsigned MBX_SYNC_STAGES = 2;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;

    typedef struct packed {
        logic cs;
        logic en;
        dir_e dir;
        logic mb;
    } port_ctl_t;

    function automatic logic ctl_active(input port_ctl_t c);
        return c.cs & c.en & c.mb;
    endfunction

    function automatic logic ctl_mb_write(input port_ctl_t c);
        return ctl_active(c) & (c.dir == DIR_WRITE);
    endfunction

    function automatic logic ctl_mb_read(input port_ctl_t c);
        return ctl_active(c) & (c.dir == DIR_READ);
    endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int unsigned N = (STAGES < 1) ? 1 : STAGES;

    logic [N-1:0] chain_q;

    generate
        if (N == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[N-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[N-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
    parameter int unsigned DATA_W      = 36,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_w,
    input  logic              clk_r,
    input  logic              rst,
    input  logic              put,
    input  logic [DATA_W-1:0] put_data,
    input  logic              take,
    output logic [DATA_W-1:0] word_q,
    output logic              free_q
);
    // writer domain
    logic wr_tgl_q;
    logic wr_tgl_d;
    logic rd_tgl_w;
    logic accept;

    // reader domain
    logic rd_tgl_q;
    logic wr_tgl_r;
    logic pending_r;

    mbx_sync #(.STAGES(SYNC_STAGES)) u_rd_to_w (
        .clk (clk_w),
        .rst (rst),
        .d   (rd_tgl_q),
        .q   (rd_tgl_w)
    );

    mbx_sync #(.STAGES(SYNC_STAGES)) u_wr_to_r (
        .clk (clk_r),
        .rst (rst),
        .d   (wr_tgl_q),
        .q   (wr_tgl_r)
    );

    assign accept   = put & free_q;
    assign wr_tgl_d = wr_tgl_q ^ accept;

    always_ff @(posedge clk_w) begin
        if (rst) begin
            wr_tgl_q <= 1'b0;
            free_q   <= 1'b1;
            word_q   <= '0;
        end else begin
            wr_tgl_q <= wr_tgl_d;
            free_q   <= (wr_tgl_d == rd_tgl_w);
            if (accept) word_q <= put_data;
        end
    end

    assign pending_r = (wr_tgl_r != rd_tgl_q);

    always_ff @(posedge clk_r) begin
        if (rst) rd_tgl_q <= 1'b0;
        else     rd_tgl_q <= rd_tgl_q ^ (take & pending_r);
    end

    // R9: reset leaves the mailbox free and empty
    assert_reset_free_R9: assert property (@(posedge clk_w)
        rst |=> (free_q && word_q == '0));

    // R2 / R3: an accepted write drops the flag on its own edge
    assert_write_clears_R2: assert property (@(posedge clk_w) disable iff (rst)
        (put && free_q) |=> !free_q);

    // R6: unread mail is never overwritten
    assert_no_overwrite_R6: assert property (@(posedge clk_w) disable iff (rst)
        !free_q |=> $stable(word_q));

    // R4 / R5: the flag rises only once the read toggle has crossed over
    assert_release_synced_R4: assert property (@(posedge clk_w) disable iff (rst)
        $rose(free_q) |-> ($past(rd_tgl_w) == wr_tgl_q));

    // R7: the reader toggles only for mail that has reached its domain
    assert_read_needs_mail_R7: assert property (@(posedge clk_r) disable iff (rst)
        (rd_tgl_q != $past(rd_tgl_q)) |-> $past(pending_r));
endmodule

// File: rtl/mbx_out_sel.sv
module mbx_out_sel #(
    parameter int unsigned DATA_W = 36
) (
    input  logic              sel_mail,
    input  logic [DATA_W-1:0] mail,
    input  logic [DATA_W-1:0] other,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        if (sel_mail) y = mail;
        else          y = other;
    end
endmodule

// File: rtl/xmbox_pair.sv
module xmbox_pair
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W      = MBX_DATA_W,
    parameter int unsigned SYNC_STAGES = MBX_SYNC_STAGES
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst,
    input  logic              a_cs,
    input  logic              a_en,
    input  logic              a_wr,
    input  logic              a_mb,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_cs,
    input  logic              b_en,
    input  logic              b_wr,
    input  logic              b_mb,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic [DATA_W-1:0] b_fifo_data,
    output logic [DATA_W-1:0] b_rdata,
    output logic              m1_free,
    output logic              m2_free
);
    localparam logic [DATA_W-1:0] ZERO_WORD = '0;

    port_ctl_t        ctl_a;
    port_ctl_t        ctl_b;
    logic [DATA_W-1:0] mail1_q;
    logic [DATA_W-1:0] mail2_q;

    assign ctl_a = '{cs: a_cs, en: a_en, dir: dir_e'(a_wr), mb: a_mb};
    assign ctl_b = '{cs: b_cs, en: b_en, dir: dir_e'(b_wr), mb: b_mb};

    // mail1: written from port A, taken by port B
    mbx_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ch_ab (
        .clk_w    (clk_a),
        .clk_r    (clk_b),
        .rst      (rst),
        .put      (ctl_mb_write(ctl_a)),
        .put_data (a_wdata),
        .take     (ctl_mb_read(ctl_b)),
        .word_q   (mail1_q),
        .free_q   (m1_free)
    );

    // mail2: written from port B, taken by port A
    mbx_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ch_ba (
        .clk_w    (clk_b),
        .clk_r    (clk_a),
        .rst      (rst),
        .put      (ctl_mb_write(ctl_b)),
        .put_data (b_wdata),
        .take     (ctl_mb_read(ctl_a)),
        .word_q   (mail2_q),
        .free_q   (m2_free)
    );

    mbx_out_sel #(.DATA_W(DATA_W)) u_sel_b (
        .sel_mail (b_mb),
        .mail     (mail1_q),
        .other    (b_fifo_data),
        .y        (b_rdata)
    );

    mbx_out_sel #(.DATA_W(DATA_W)) u_sel_a (
        .sel_mail (a_mb),
        .mail     (mail2_q),
        .other    (ZERO_WORD),
        .y        (a_rdata)
    );
endmodule

// File: tb/xmbox_pair_bench.sv
`timescale 1ns/10ps
module xmbox_pair_bench;
    logic        clk_a = 1'b0;
    logic        clk_b = 1'b0;
    logic        rst   = 1'b1;
    logic        a_cs = 0, a_en = 0, a_wr = 0, a_mb = 0;
    logic        b_cs = 0, b_en = 0, b_wr = 0, b_mb = 0;
    logic [35:0] a_wdata = '0, b_wdata = '0, b_fifo_data = '0;
    logic [35:0] a_rdata, b_rdata;
    logic        m1_free, m2_free;

    int checks = 0;
    int errors = 0;

    // clk_a 200 MHz: rising edges at 2.5 + 5k ns
    always #2.5 clk_a = ~clk_a;
    // clk_b: rising edges at 4.0 + 7k ns, never closer than 0.5 ns to clk_a
    initial begin
        #0.5;
        forever #3.5 clk_b = ~clk_b;
    end

    xmbox_pair u_xmbox_pair (
        .clk_a(clk_a), .clk_b(clk_b), .rst(rst),
        .a_cs(a_cs), .a_en(a_en), .a_wr(a_wr), .a_mb(a_mb),
        .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_cs(b_cs), .b_en(b_en), .b_wr(b_wr), .b_mb(b_mb),
        .b_wdata(b_wdata), .b_fifo_data(b_fifo_data), .b_rdata(b_rdata),
        .m1_free(m1_free), .m2_free(m2_free)
    );

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic a_access(input logic cs, en, wr, mb, input logic [35:0] d);
        @(posedge clk_a); #0.2;
        a_cs = cs; a_en = en; a_wr = wr; a_mb = mb; a_wdata = d;
        @(posedge clk_a); #0.2;
        a_cs = 0; a_en = 0; a_wr = 0; a_wdata = '0;
    endtask

    task automatic b_access(input logic cs, en, wr, mb, input logic [35:0] d);
        @(posedge clk_b); #0.2;
        b_cs = cs; b_en = en; b_wr = wr; b_mb = mb; b_wdata = d;
        @(posedge clk_b); #0.2;
        b_cs = 0; b_en = 0; b_wr = 0; b_wdata = '0;
    endtask

    task automatic wait_a(input int n);
        for (int i = 0; i < n; i++) @(posedge clk_a);
        #0.2;
    endtask

    task automatic wait_b(input int n);
        for (int i = 0; i < n; i++) @(posedge clk_b);
        #0.2;
    endtask

    task automatic test_reset();
        b_mb = 1; a_mb = 1; #0.1;
        chk("R9 m1_free after reset", 36'(m1_free), 36'd1);
        chk("R9 m2_free after reset", 36'(m2_free), 36'd1);
        chk("R9 mail1 cleared", b_rdata, 36'd0);
        chk("R9 mail2 cleared", a_rdata, 36'd0);
    endtask

    task automatic test_mux();
        b_fifo_data = 36'h9_1234_5678;
        b_mb = 0; a_mb = 0; #0.1;
        chk("R8 b_rdata shows queue word", b_rdata, 36'h9_1234_5678);
        chk("R8 a_rdata zero without mb", a_rdata, 36'd0);
        b_fifo_data = 36'h0_0F0F_0F0F; #0.1;
        chk("R8 b_rdata follows queue word", b_rdata, 36'h0_0F0F_0F0F);
    endtask

    task automatic test_gating();
        a_access(0, 1, 1, 1, 36'hA_AAAA_0001);
        a_access(1, 0, 1, 1, 36'hA_AAAA_0002);
        a_access(1, 1, 1, 0, 36'hA_AAAA_0003);
        b_mb = 1; #0.1;
        chk("R1 gated writes leave m1_free", 36'(m1_free), 36'd1);
        chk("R1 gated writes leave mail1", b_rdata, 36'd0);
    endtask

    task automatic test_a_to_b();
        a_access(1, 1, 1, 1, 36'h1_2345_6789);
        chk("R2 m1_free low on write edge", 36'(m1_free), 36'd0);
        wait_b(3);
        b_mb = 1; #0.1;
        chk("R2 mail1 data at port B", b_rdata, 36'h1_2345_6789);
        // a read with enable low must not release the flag
        b_access(1, 0, 0, 1, '0);
        wait_a(6);
        chk("R1 disabled read keeps m1_free low", 36'(m1_free), 36'd0);
        b_access(1, 1, 0, 1, '0);
        wait_a(2);
        chk("R4 m1_free low after 2nd A edge", 36'(m1_free), 36'd0);
        wait_a(1);
        chk("R4 m1_free high on 3rd A edge", 36'(m1_free), 36'd1);
    endtask

    task automatic test_b_to_a();
        b_access(1, 1, 1, 1, 36'hF_EDCB_A987);
        chk("R3 m2_free low on write edge", 36'(m2_free), 36'd0);
        wait_a(3);
        a_mb = 1; #0.1;
        chk("R3 mail2 data at port A", a_rdata, 36'hF_EDCB_A987);
        a_access(1, 1, 0, 1, '0);
        wait_b(2);
        chk("R5 m2_free low after 2nd B edge", 36'(m2_free), 36'd0);
        wait_b(1);
        chk("R5 m2_free high on 3rd B edge", 36'(m2_free), 36'd1);
    endtask

    task automatic test_blocked();
        a_access(1, 1, 1, 1, 36'h2_2222_2222);
        a_access(1, 1, 1, 1, 36'h3_3333_3333);
        wait_a(10);
        b_mb = 1; #0.1;
        chk("R6 unread mail1 not overwritten", b_rdata, 36'h2_2222_2222);
        chk("R6 m1_free stays low", 36'(m1_free), 36'd0);
        wait_b(1);
        b_access(1, 1, 0, 1, '0);
        wait_a(4);
        chk("R4 release after blocked write", 36'(m1_free), 36'd1);
        a_access(1, 1, 1, 1, 36'h3_3333_3333);
        wait_b(1);
        chk("R2 write accepted once free", b_rdata, 36'h3_3333_3333);
        wait_b(3);
        b_access(1, 1, 0, 1, '0);
        wait_a(4);
    endtask

    task automatic test_stale_read();
        chk("R7 precondition m1_free high", 36'(m1_free), 36'd1);
        b_access(1, 1, 0, 1, '0);
        wait_a(6);
        chk("R7 empty read leaves m1_free high", 36'(m1_free), 36'd1);
        a_access(1, 1, 1, 1, 36'h4_4444_4444);
        wait_a(10);
        chk("R7 empty read did not pre-release", 36'(m1_free), 36'd0);
    endtask

    task automatic test_cross();
        a_mb = 1; b_mb = 1; #0.1;
        chk("R8 port A reads mail2, not its own mail1", a_rdata, 36'hF_EDCB_A987);
        chk("R8 port B reads mail1", b_rdata, 36'h4_4444_4444);
        b_access(1, 1, 1, 1, 36'h5_5555_5555);
        wait_a(3);
        chk("R8 port A sees new mail2", a_rdata, 36'h5_5555_5555);
        chk("R8 port B still sees mail1", b_rdata, 36'h4_4444_4444);
    endtask

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_a(6);
        wait_b(6);
        rst = 0;
        wait_a(2);
        test_reset();
        test_mux();
        test_gating();
        test_a_to_b();
        test_b_to_a();
        test_blocked();
        test_stale_read();
        test_cross();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule